// File: doc/BRIEF.md
# Endian-Aware Load/Store Data Aligner

This block sits between a 32-bit data bus and the register file of a processor core. It formats byte and word transfers in both directions. On a load, it takes the bus word, the two low address bits, a byte/word select and an endianness setting. For a byte load, it picks one byte lane and zero-fills the upper bits. For a word load at a misaligned address, it rotates the word instead of raising a fault. The load result is registered and appears one cycle after the bus data, together with a valid strobe.

On a store, the block forms the value driven onto the bus. A byte store copies the low byte of the source into every lane, and the memory system decides which lane to write. A word store passes the source through unchanged, whatever the address. When the program counter is the store source, the block adds a fixed adjustment (12 by default) to the supplied instruction address and stores that sum. The store path is purely combinational.

Top module: `ldst_align`

## Requirements
- R1: While `rst_n` is low and after its release, `ld_valid_o` is 0 and `ld_data_o` is all zeros until the first load is captured.
- R2: `ld_valid_o` is asserted exactly one clock after `ld_valid_i` was sampled high. A cycle with `ld_valid_i` low deasserts `ld_valid_o` one clock later and leaves `ld_data_o` unchanged.
- R3: When `big_endian_i`=0, a byte load (`ld_byte_i`=1) returns bus bits [8k+7:8k] for `addr_lo_i`=k, so offset 0 gives bits 7:0 and offset 3 gives bits 31:24.
- R4: When `big_endian_i`=1, a byte load returns bus bits [31-8k:24-8k] for `addr_lo_i`=k, so offset 0 gives bits 31:24 and offset 3 gives bits 7:0.
- R5: A byte load places the chosen byte in `ld_data_o[7:0]` and sets `ld_data_o[31:8]` to zero.
- R6: When `big_endian_i`=0, a word load (`ld_byte_i`=0) rotates the bus word so that the byte addressed by `addr_lo_i` ends up in bits 7:0. Offset 0 returns the word unchanged.
- R7: When `big_endian_i`=1, a word load rotates the bus word so that the addressed byte lands in bits 31:24 for offsets 0 and 2, and in bits 15:8 for offsets 1 and 3.
- R8: A byte store (`st_byte_i`=1) drives the low 8 bits of the store value onto all four byte lanes of `st_bus_o`.
- R9: A word store (`st_byte_i`=0, `st_from_pc_i`=0) drives `st_src_i` unchanged on `st_bus_o` for every `addr_lo_i` value, so source bit 31 always appears on bus bit 31.
- R10: When `st_from_pc_i`=1, the store value is `st_pc_i` + 12, computed modulo 2^32, in place of `st_src_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the load result register |
| big_endian_i | input | 1 | 1 selects big-endian lane numbering, 0 selects little-endian |
| addr_lo_i | input | 2 | Low two bits of the transfer address |
| ld_valid_i | input | 1 | Load bus data is valid this cycle |
| ld_byte_i | input | 1 | 1 selects a byte load, 0 a word load |
| ld_bus_i | input | 32 | Word read from the data bus |
| ld_valid_o | output | 1 | Registered load result is valid |
| ld_data_o | output | 32 | Registered value for the destination register |
| st_byte_i | input | 1 | 1 selects a byte store, 0 a word store |
| st_from_pc_i | input | 1 | The store source is the program counter |
| st_src_i | input | 32 | Source register value for the store |
| st_pc_i | input | 32 | Address of the current store instruction |
| st_bus_o | output | 32 | Value driven onto the data bus |

## Verification
The bench walks through all four offsets in both endian modes for byte and word loads, using a bus word whose bytes are all distinct. A design that mirrors lanes the wrong way would return the byte at the opposite offset. One that shifts the word instead of rotating it would lose bytes or leave holes of zeros. One that uses the little-endian placement for big-endian offsets 1 and 3 would put the byte in bits 7:0 instead of 15:8. Store checks cover misaligned word addresses, where a design that wrongly rotated stores would scramble the bus. They also cover a program-counter source near the top of the address space, where the adjustment must wrap, and a byte store of that adjusted value. A hold cycle with the valid input low catches a result register that updates without the strobe.

// File: rtl/ldst_align_pkg.sv
package ldst_align_pkg;

   typedef enum logic {
      ORDER_LITTLE = 1'b0,
      ORDER_BIG    = 1'b1
   } byte_order_e;

   typedef enum logic {
      XFER_WORD = 1'b0,
      XFER_BYTE = 1'b1
   } xfer_size_e;

   // number of byte lanes in a word of the given width
   function automatic int unsigned lanes_in(input int unsigned word_w,
                                            input int unsigned lane_w);
      return word_w / lane_w;
   endfunction

endpackage

// File: rtl/ldst_lane_pick.sv
module ldst_lane_pick #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned OFS_W  = 2
) (
   input  logic [LANES*LANE_W-1:0] word_i,
   input  logic [OFS_W-1:0]        ofs_i,
   input  logic                    big_i,
   output logic [LANE_W-1:0]       lane_o
);
   import ldst_align_pkg::*;

   logic [OFS_W-1:0] lane_idx;

   // big-endian numbering counts lanes from the most significant end
   always_comb begin
      if (byte_order_e'(big_i) == ORDER_BIG)
         lane_idx = OFS_W'(LANES - 1) - ofs_i;
      else
         lane_idx = ofs_i;
   end

   assign lane_o = word_i[lane_idx*LANE_W +: LANE_W];

endmodule

// File: rtl/ldst_word_rot.sv
module ldst_word_rot #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned OFS_W  = 2
) (
   input  logic [LANES*LANE_W-1:0] word_i,
   input  logic [OFS_W-1:0]        ofs_i,
   output logic [LANES*LANE_W-1:0] word_o
);
   // Rotate right by ofs_i lanes. For either byte order, this moves the
   // addressed lane to the position the register expects.
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [OFS_W-1:0] src;
      assign src = ofs_i + OFS_W'(j);
      assign word_o[j*LANE_W +: LANE_W] = word_i[src*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/ldst_store_fmt.sv
module ldst_store_fmt #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned PC_ADJ = 12
) (
   input  logic [LANES*LANE_W-1:0] src_i,
   input  logic [LANES*LANE_W-1:0] pc_i,
   input  logic                    from_pc_i,
   input  logic                    byte_i,
   output logic [LANES*LANE_W-1:0] bus_o
);
   import ldst_align_pkg::*;

   localparam int unsigned WORD_W = LANES * LANE_W;

   logic [WORD_W-1:0] value;

   assign value = from_pc_i ? (pc_i + WORD_W'(PC_ADJ)) : src_i;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign bus_o[j*LANE_W +: LANE_W] =
         (xfer_size_e'(byte_i) == XFER_BYTE) ? value[LANE_W-1:0]
                                             : value[j*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/ldst_align.sv
module ldst_align #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned LANE_W       = 8,
   parameter int unsigned PC_STORE_ADJ = 12,
   localparam int unsigned LANES       = ldst_align_pkg::lanes_in(DATA_W, LANE_W),
   localparam int unsigned OFS_W       = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian_i,
   input  logic [OFS_W-1:0]  addr_lo_i,
   input  logic              ld_valid_i,
   input  logic              ld_byte_i,
   input  logic [DATA_W-1:0] ld_bus_i,
   output logic              ld_valid_o,
   output logic [DATA_W-1:0] ld_data_o,
   input  logic              st_byte_i,
   input  logic              st_from_pc_i,
   input  logic [DATA_W-1:0] st_src_i,
   input  logic [DATA_W-1:0] st_pc_i,
   output logic [DATA_W-1:0] st_bus_o
);
   import ldst_align_pkg::*;

   // elaboration-time parameter checks
   if (DATA_W % LANE_W != 0) begin : g_bad_width
      $error("ldst_align: DATA_W must be a multiple of LANE_W");
   end
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("ldst_align: lane count must be a power of two, at least 2");
   end

   logic [LANE_W-1:0] picked;
   logic [DATA_W-1:0] rotated;
   logic [DATA_W-1:0] ld_next;

   ldst_lane_pick #(.LANE_W(LANE_W), .LANES(LANES), .OFS_W(OFS_W)) u_pick (
      .word_i (ld_bus_i),
      .ofs_i  (addr_lo_i),
      .big_i  (big_endian_i),
      .lane_o (picked)
   );

   ldst_word_rot #(.LANE_W(LANE_W), .LANES(LANES), .OFS_W(OFS_W)) u_rot (
      .word_i (ld_bus_i),
      .ofs_i  (addr_lo_i),
      .word_o (rotated)
   );

   always_comb begin
      if (xfer_size_e'(ld_byte_i) == XFER_BYTE)
         ld_next = {{(DATA_W-LANE_W){1'b0}}, picked};
      else
         ld_next = rotated;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_valid_o <= 1'b0;
         ld_data_o  <= '0;
      end else begin
         ld_valid_o <= ld_valid_i;
         if (ld_valid_i)
            ld_data_o <= ld_next;
      end
   end

   ldst_store_fmt #(.LANE_W(LANE_W), .LANES(LANES), .PC_ADJ(PC_STORE_ADJ)) u_st (
      .src_i     (st_src_i),
      .pc_i      (st_pc_i),
      .from_pc_i (st_from_pc_i),
      .byte_i    (st_byte_i),
      .bus_o     (st_bus_o)
   );

endmodule

// File: rtl/ldst_align_chk.sv
module ldst_align_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned PC_ADJ = 12,
   parameter int unsigned LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_valid_i,
   input logic              ld_byte_i,
   input logic [DATA_W-1:0] ld_bus_i,
   input logic              ld_valid_o,
   input logic [DATA_W-1:0] ld_data_o,
   input logic              st_byte_i,
   input logic              st_from_pc_i,
   input logic [DATA_W-1:0] st_src_i,
   input logic [DATA_W-1:0] st_pc_i,
   input logic [DATA_W-1:0] st_bus_o
);

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid_i |=> ld_valid_o);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid_i |=> (!ld_valid_o && $stable(ld_data_o)));

   // R5
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_i && ld_byte_i) |=> (ld_data_o[DATA_W-1:LANE_W] == '0));

   // R6 R7: a rotation keeps every bit of the bus word
   rot_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_i && !ld_byte_i) |=>
         ($countones(ld_data_o) == $past($countones(ld_bus_i))));

   // R8
   byte_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_byte_i |-> (st_bus_o == {LANES{st_bus_o[LANE_W-1:0]}}));

   // R9
   word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_byte_i && !st_from_pc_i) |-> (st_bus_o == st_src_i));

   // R10
   pc_adjust_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_byte_i && st_from_pc_i) |-> (st_bus_o == st_pc_i + DATA_W'(PC_ADJ)));

endmodule

bind ldst_align ldst_align_chk #(
   .DATA_W (DATA_W),
   .LANE_W (LANE_W),
   .PC_ADJ (PC_STORE_ADJ),
   .LANES  (LANES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ld_valid_i   (ld_valid_i),
   .ld_byte_i    (ld_byte_i),
   .ld_bus_i     (ld_bus_i),
   .ld_valid_o   (ld_valid_o),
   .ld_data_o    (ld_data_o),
   .st_byte_i    (st_byte_i),
   .st_from_pc_i (st_from_pc_i),
   .st_src_i     (st_src_i),
   .st_pc_i      (st_pc_i),
   .st_bus_o     (st_bus_o)
);

// File: tb/ldst_align_test.sv
module ldst_align_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        big_endian_i;
   logic [1:0]  addr_lo_i;
   logic        ld_valid_i;
   logic        ld_byte_i;
   logic [31:0] ld_bus_i;
   logic        ld_valid_o;
   logic [31:0] ld_data_o;
   logic        st_byte_i;
   logic        st_from_pc_i;
   logic [31:0] st_src_i;
   logic [31:0] st_pc_i;
   logic [31:0] st_bus_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   ldst_align uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .big_endian_i (big_endian_i),
      .addr_lo_i    (addr_lo_i),
      .ld_valid_i   (ld_valid_i),
      .ld_byte_i    (ld_byte_i),
      .ld_bus_i     (ld_bus_i),
      .ld_valid_o   (ld_valid_o),
      .ld_data_o    (ld_data_o),
      .st_byte_i    (st_byte_i),
      .st_from_pc_i (st_from_pc_i),
      .st_src_i     (st_src_i),
      .st_pc_i      (st_pc_i),
      .st_bus_o     (st_bus_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected load value, built from the lane-placement rules
   function automatic logic [31:0] exp_load(input logic [31:0] bus, input int ofs,
                                            input bit byte_sel, input bit be);
      int src_lane;
      int dst_lane;
      int r;
      logic [31:0] res;
      src_lane = be ? 3 - ofs : ofs;
      if (byte_sel) return {24'h0, bus[src_lane*8 +: 8]};
      if (!be) dst_lane = 0;
      else     dst_lane = (ofs % 2 == 0) ? 3 : 1;
      r = (src_lane - dst_lane + 4) % 4;
      res = bus;
      for (int k = 0; k < r; k++) res = {res[7:0], res[31:8]};
      return res;
   endfunction

   function automatic logic [31:0] exp_store(input logic [31:0] src, input logic [31:0] pc,
                                             input bit from_pc, input bit byte_sel);
      logic [31:0] v;
      v = from_pc ? pc + 32'd12 : src;
      return byte_sel ? {4{v[7:0]}} : v;
   endfunction

   function automatic string load_req(input bit be, input bit byte_sel);
      if (byte_sel) return be ? "R4" : "R3";
      return be ? "R7" : "R6";
   endfunction

   task automatic do_load(input logic [31:0] bus, input int ofs, input bit byte_sel, input bit be);
      @(negedge clk);
      ld_bus_i     = bus;
      addr_lo_i    = 2'(ofs);
      ld_byte_i    = byte_sel;
      big_endian_i = be;
      ld_valid_i   = 1'b1;
      @(negedge clk);
      check("R2 valid", {31'h0, ld_valid_o}, 32'h1);
      check(load_req(be, byte_sel), ld_data_o, exp_load(bus, ofs, byte_sel, be));
      if (byte_sel) check("R5 zero fill", {8'h0, ld_data_o[31:8]}, 32'h0);
   endtask

   task automatic do_store(input logic [31:0] src, input logic [31:0] pc,
                           input bit from_pc, input bit byte_sel, input int ofs, input string req);
      @(negedge clk);
      st_src_i     = src;
      st_pc_i      = pc;
      st_from_pc_i = from_pc;
      st_byte_i    = byte_sel;
      addr_lo_i    = 2'(ofs);
      #1;
      check(req, st_bus_o, exp_store(src, pc, from_pc, byte_sel));
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      void'($urandom(32'd1234));
      rst_n = 1'b0;
      big_endian_i = 1'b0; addr_lo_i = 2'd0; ld_valid_i = 1'b0; ld_byte_i = 1'b0;
      ld_bus_i = 32'h0; st_byte_i = 1'b0; st_from_pc_i = 1'b0; st_src_i = 32'h0; st_pc_i = 32'h0;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", {31'h0, ld_valid_o}, 32'h0);
      check("R1 data in reset", ld_data_o, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", {31'h0, ld_valid_o}, 32'h0);
      check("R1 data after reset", ld_data_o, 32'h0);

      // directed: every offset, both orders, both sizes, distinct bytes
      for (int be = 0; be < 2; be++)
         for (int bs = 0; bs < 2; bs++)
            for (int o = 0; o < 4; o++)
               do_load(32'h44332211, o, bit'(bs), bit'(be));

      // R2: idle cycle keeps data and drops valid
      held = ld_data_o;
      @(negedge clk);
      ld_valid_i = 1'b0;
      ld_bus_i   = 32'hDEADBEEF;
      @(negedge clk);
      check("R2 valid drop", {31'h0, ld_valid_o}, 32'h0);
      check("R2 data hold", ld_data_o, held);

      // random loads
      for (int i = 0; i < 400; i++)
         do_load($urandom, int'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2));

      @(negedge clk);
      ld_valid_i = 1'b0;

      // directed stores
      do_store(32'hA1B2C3D4, 32'h0, 1'b0, 1'b1, 2, "R8 byte copy");
      for (int o = 0; o < 4; o++)
         do_store(32'h80C3A501, 32'h0, 1'b0, 1'b0, o, "R9 word pass");
      do_store(32'h0, 32'h00001000, 1'b1, 1'b0, 0, "R10 pc adjust");
      do_store(32'h0, 32'hFFFFFFF8, 1'b1, 1'b0, 1, "R10 pc wrap");
      do_store(32'h0, 32'h000020F6, 1'b1, 1'b1, 3, "R8 R10 byte of pc");

      // random stores
      for (int i = 0; i < 200; i++)
         do_store($urandom, $urandom, bit'($urandom % 2), bit'($urandom % 2),
                  int'($urandom % 4), "R8 R9 R10 random store");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule